// File: doc/BRIEF.md
# Privilege-Aware Segment Address Mapper

This block turns a 32-bit virtual address into a physical address using a fixed split of the address space into 512 MB segment windows. The current privilege mode and an error-level status bit decide which windows are legal, which are translated by a fixed subtraction, and which have to go to an external translation buffer. For mapped addresses the block sends a lookup request out and takes the buffer's hit, valid, dirty and frame-number result back in the same cycle. The buffer contents are not part of this block.

Any failure becomes one exception code with a refill flag. In the cycle after a failed request, three translation context registers are updated: the faulting-address register, the context register (whose page-number field is overwritten while its other bits are kept) and the entry-high register (virtual page pair plus the current 8-bit address-space ID). A whole-word load port for the context register lets software set the bits that faults keep.

Top module: `seg_addr_mapper`

## Requirements
- R1: With `err_level`=1, any address below 0x80000000 maps to itself in every privilege mode, with `phys_ok`, read and write permission set and no TLB request.
- R2: With `err_level`=0, an address below 0x80000000 asserts `tlb_req` with `tlb_vpn2`=vaddr[31:13] and `tlb_odd`=vaddr[12]. On a valid hit the physical address is {`tlb_pfn`, vaddr[11:0]}, read permission is 1 and write permission equals `tlb_dirty`.
- R3: Privilege is encoded 00 kernel, 01 supervisor, 10 user, with 11 treated as user. Addresses 0x80000000–0x9FFFFFFF are legal only in kernel mode and map to vaddr−0x80000000 with read and write permission.
- R4: Addresses 0xA0000000–0xBFFFFFFF are legal only in kernel mode and map to vaddr−0xA0000000 with read and write permission.
- R5: Addresses 0xC0000000–0xDFFFFFFF go to the TLB in supervisor or kernel mode. Addresses from 0xE0000000 up go to the TLB in kernel mode only.
- R6: An access to a window that the mode may not use gives exception code 5 on a write and 4 on a read, with refill 0 and no TLB request.
- R7: A TLB miss gives code 3 on a write and 2 on a read, with refill 1.
- R8: A TLB hit on an entry that is not valid gives code 3 on a write and 2 on a read, with refill 0.
- R9: A write that hits a valid entry that is not dirty gives code 1 with refill 0. A read of the same entry succeeds.
- R10: All three registers reset to zero. A failed request makes `bad_vaddr` equal the address one cycle later. A successful or absent request raises no exception, and without a context load it leaves all three registers unchanged. With `req_valid`=0 there is no exception, no TLB request and no `phys_ok`.
- R11: On a fault, context bits [22:4] become vaddr[31:13] and the other bits keep their value. `ctx_load` writes the whole register. If a load and a fault happen in the same cycle, bits [22:4] come from the fault and the other bits come from the load data.
- R12: On a fault, `entry_hi` becomes {vaddr[31:13], 5'b0, `cur_id`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| priv_mode | input | 2 | 00 kernel, 01 supervisor, 10 user |
| err_level | input | 1 | Error-level status bit |
| cur_id | input | 8 | Current address-space ID |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_valid | input | 1 | Matching page is valid |
| tlb_dirty | input | 1 | Matching page is writable |
| tlb_pfn | input | 20 | Page frame number of the matching page |
| ctx_load | input | 1 | Load the context register |
| ctx_load_data | input | 32 | Value for the context load |
| tlb_req | output | 1 | Lookup request to the TLB |
| tlb_vpn2 | output | 19 | Virtual page-pair number sent to the TLB |
| tlb_odd | output | 1 | Odd page of the pair selected |
| phys_ok | output | 1 | Translation succeeded |
| phys_addr | output | 32 | Physical address (zero unless phys_ok) |
| perm_rd | output | 1 | Page readable |
| perm_wr | output | 1 | Page writable |
| exc_valid | output | 1 | Translation failed |
| exc_code | output | 5 | Exception code (1, 2, 3, 4, 5) |
| exc_refill | output | 1 | Failure was a TLB miss |
| bad_vaddr | output | 32 | Faulting-address register |
| ctx_reg | output | 32 | Context register |
| entry_hi | output | 32 | Entry-high register |

## Verification
A software load of the context register and a fault capture can land on the same clock edge, and both write the same register. The bench drives `ctx_load` with a known pattern in the same cycle as an illegal or missing access, and also the load alone and the fault alone. After the edge it compares each bit field of the register against a reference model: the fault owns bits [22:4] and the load data owns the rest. A second kind of overlap, a valid hit with a write to a clean page, is judged by the code being 1 while the registers still capture.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int VA_W      = 32;
    localparam int PG_OFS_W  = 12;
    localparam int VPN2_W    = VA_W - PG_OFS_W - 1;
    localparam int WIN_OFS_W = 29;

    typedef enum logic [1:0] {
        PRIV_KERN = 2'b00,
        PRIV_SUPV = 2'b01,
        PRIV_USER = 2'b10,
        PRIV_RSVD = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        RT_IDENT   = 2'd0,
        RT_WINDOW  = 2'd1,
        RT_MAPPED  = 2'd2,
        RT_ILLEGAL = 2'd3
    } route_e;

    typedef enum logic [4:0] {
        EXC_NONE   = 5'd0,
        EXC_MODIFY = 5'd1,
        EXC_TLB_LD = 5'd2,
        EXC_TLB_ST = 5'd3,
        EXC_ADR_LD = 5'd4,
        EXC_ADR_ST = 5'd5
    } exc_e;

    typedef struct packed {
        logic valid;
        exc_e code;
        logic refill;
    } fault_t;

    function automatic logic is_kernel(priv_e p);
        return p == PRIV_KERN;
    endfunction

    function automatic logic is_super_or_kernel(priv_e p);
        return (p == PRIV_KERN) || (p == PRIV_SUPV);
    endfunction

endpackage

// File: rtl/amap_seg_decode.sv
module amap_seg_decode
    import amap_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  priv_e           priv,
    input  logic            err_lvl,
    output route_e          route,
    output logic [VA_W-1:0] unmapped_pa
);
    always_comb begin
        route = RT_ILLEGAL;
        if (!va[VA_W-1]) begin
            route = err_lvl ? RT_IDENT : RT_MAPPED;
        end else begin
            case (va[VA_W-2:VA_W-3])
                2'b00, 2'b01: route = is_kernel(priv) ? RT_WINDOW : RT_ILLEGAL;
                2'b10:        route = is_super_or_kernel(priv) ? RT_MAPPED : RT_ILLEGAL;
                default:      route = is_kernel(priv) ? RT_MAPPED : RT_ILLEGAL;
            endcase
        end
    end

    // Both kernel windows drop the three top bits; the low segment passes through.
    assign unmapped_pa = (route == RT_IDENT) ? va
                                             : {{(VA_W-WIN_OFS_W){1'b0}}, va[WIN_OFS_W-1:0]};
endmodule

// File: rtl/amap_fault_classify.sv
module amap_fault_classify
    import amap_pkg::*;
(
    input  logic   req_valid,
    input  logic   write,
    input  route_e route,
    input  logic   hit,
    input  logic   pg_valid,
    input  logic   pg_dirty,
    output fault_t fault,
    output logic   ok,
    output logic   rd,
    output logic   wr
);
    always_comb begin
        fault.valid  = 1'b0;
        fault.code   = EXC_NONE;
        fault.refill = 1'b0;
        ok = 1'b0;
        rd = 1'b0;
        wr = 1'b0;
        if (req_valid) begin
            case (route)
                RT_IDENT, RT_WINDOW: begin
                    ok = 1'b1;
                    rd = 1'b1;
                    wr = 1'b1;
                end
                RT_MAPPED: begin
                    if (!hit) begin
                        fault.valid  = 1'b1;
                        fault.code   = write ? EXC_TLB_ST : EXC_TLB_LD;
                        fault.refill = 1'b1;
                    end else if (!pg_valid) begin
                        fault.valid = 1'b1;
                        fault.code  = write ? EXC_TLB_ST : EXC_TLB_LD;
                    end else if (write && !pg_dirty) begin
                        fault.valid = 1'b1;
                        fault.code  = EXC_MODIFY;
                    end else begin
                        ok = 1'b1;
                        rd = 1'b1;
                        wr = pg_dirty;
                    end
                end
                default: begin
                    fault.valid = 1'b1;
                    fault.code  = write ? EXC_ADR_ST : EXC_ADR_LD;
                end
            endcase
        end
    end
endmodule

// File: rtl/amap_fault_regs.sv
module amap_fault_regs
    import amap_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [VA_W-1:0] va,
    input  logic [ID_W-1:0] id,
    input  logic            ctx_load,
    input  logic [VA_W-1:0] ctx_data,
    output logic [VA_W-1:0] bad_q,
    output logic [VA_W-1:0] ctx_q,
    output logic [VA_W-1:0] ehi_q
);
    localparam int CTX_LO  = 4;
    localparam int CTX_HI  = CTX_LO + VPN2_W - 1;
    localparam int EHI_GAP = PG_OFS_W + 1 - ID_W;

    logic [VA_W-1:0] ctx_next;

    always_comb begin
        ctx_next = ctx_load ? ctx_data : ctx_q;
        if (capture) ctx_next[CTX_HI:CTX_LO] = va[VA_W-1:PG_OFS_W+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_q <= '0;
            ctx_q <= '0;
            ehi_q <= '0;
        end else begin
            ctx_q <= ctx_next;
            if (capture) begin
                bad_q <= va;
                ehi_q <= {va[VA_W-1:PG_OFS_W+1], {EHI_GAP{1'b0}}, id};
            end
        end
    end

    a_r10_bad_capture: assert property (@(posedge clk) disable iff (rst)
        capture |=> bad_q == $past(va));
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!capture && !ctx_load) |=> ($stable(bad_q) && $stable(ctx_q) && $stable(ehi_q)));
    a_r11_ctx_keep: assert property (@(posedge clk) disable iff (rst)
        (capture && !ctx_load) |=> (ctx_q[VA_W-1:CTX_HI+1] == $past(ctx_q[VA_W-1:CTX_HI+1])
                                    && ctx_q[CTX_LO-1:0] == $past(ctx_q[CTX_LO-1:0])));
    a_r12_ehi_id: assert property (@(posedge clk) disable iff (rst)
        capture |=> (ehi_q[ID_W-1:0] == $past(id) && ehi_q[PG_OFS_W:ID_W] == '0));
endmodule

// File: rtl/seg_addr_mapper.sv
module seg_addr_mapper
    import amap_pkg::*;
#(
    parameter int PA_W = 32,
    parameter int ID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic [1:0]        priv_mode,
    input  logic              err_level,
    input  logic [ID_W-1:0]   cur_id,
    input  logic              tlb_hit,
    input  logic              tlb_valid,
    input  logic              tlb_dirty,
    input  logic [PA_W-13:0]  tlb_pfn,
    input  logic              ctx_load,
    input  logic [31:0]       ctx_load_data,
    output logic              tlb_req,
    output logic [18:0]       tlb_vpn2,
    output logic              tlb_odd,
    output logic              phys_ok,
    output logic [PA_W-1:0]   phys_addr,
    output logic              perm_rd,
    output logic              perm_wr,
    output logic              exc_valid,
    output logic [4:0]        exc_code,
    output logic              exc_refill,
    output logic [31:0]       bad_vaddr,
    output logic [31:0]       ctx_reg,
    output logic [31:0]       entry_hi
);
    priv_e           priv;
    route_e          route;
    logic [VA_W-1:0] win_pa;
    fault_t          fault;
    logic            ok;

    assign priv = priv_e'(priv_mode);

    amap_seg_decode u_dec (
        .va          (req_vaddr),
        .priv        (priv),
        .err_lvl     (err_level),
        .route       (route),
        .unmapped_pa (win_pa)
    );

    amap_fault_classify u_cls (
        .req_valid (req_valid),
        .write     (req_write),
        .route     (route),
        .hit       (tlb_hit),
        .pg_valid  (tlb_valid),
        .pg_dirty  (tlb_dirty),
        .fault     (fault),
        .ok        (ok),
        .rd        (perm_rd),
        .wr        (perm_wr)
    );

    amap_fault_regs #(.ID_W(ID_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .capture  (fault.valid),
        .va       (req_vaddr),
        .id       (cur_id),
        .ctx_load (ctx_load),
        .ctx_data (ctx_load_data),
        .bad_q    (bad_vaddr),
        .ctx_q    (ctx_reg),
        .ehi_q    (entry_hi)
    );

    assign tlb_req    = req_valid && (route == RT_MAPPED);
    assign tlb_vpn2   = req_vaddr[VA_W-1:PG_OFS_W+1];
    assign tlb_odd    = req_vaddr[PG_OFS_W];
    assign phys_ok    = ok;
    assign exc_valid  = fault.valid;
    assign exc_code   = fault.code;
    assign exc_refill = fault.refill;

    always_comb begin
        phys_addr = '0;
        if (ok) begin
            if (route == RT_MAPPED) phys_addr = {tlb_pfn, req_vaddr[PG_OFS_W-1:0]};
            else                    phys_addr = PA_W'(win_pa);
        end
    end

    a_r1_identity: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_vaddr[31] && err_level) |->
            (phys_ok && phys_addr == PA_W'(req_vaddr) && !tlb_req));
    a_r3_kernel_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vaddr[31:30] == 2'b10 && priv_mode != 2'b00) |->
            (exc_valid && (exc_code == 5'd4 || exc_code == 5'd5) && !tlb_req));
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(exc_valid && phys_ok));
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!exc_valid && !tlb_req && !phys_ok));
endmodule

// File: tb/sim_seg_addr_mapper.sv
`timescale 1ns/1ps
module sim_seg_addr_mapper;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, err_level, tlb_hit, tlb_valid, tlb_dirty, ctx_load;
    logic [31:0] req_vaddr, ctx_load_data;
    logic [1:0]  priv_mode;
    logic [7:0]  cur_id;
    logic [19:0] tlb_pfn;
    logic        tlb_req, tlb_odd, phys_ok, perm_rd, perm_wr, exc_valid, exc_refill;
    logic [18:0] tlb_vpn2;
    logic [31:0] phys_addr, bad_vaddr, ctx_reg, entry_hi;
    logic [4:0]  exc_code;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_bad = 0, m_ctx = 0, m_ehi = 0;

    always #2.5 clk = ~clk;

    seg_addr_mapper u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .priv_mode(priv_mode), .err_level(err_level),
        .cur_id(cur_id), .tlb_hit(tlb_hit), .tlb_valid(tlb_valid),
        .tlb_dirty(tlb_dirty), .tlb_pfn(tlb_pfn), .ctx_load(ctx_load),
        .ctx_load_data(ctx_load_data), .tlb_req(tlb_req), .tlb_vpn2(tlb_vpn2),
        .tlb_odd(tlb_odd), .phys_ok(phys_ok), .phys_addr(phys_addr),
        .perm_rd(perm_rd), .perm_wr(perm_wr), .exc_valid(exc_valid),
        .exc_code(exc_code), .exc_refill(exc_refill), .bad_vaddr(bad_vaddr),
        .ctx_reg(ctx_reg), .entry_hi(entry_hi)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic rv, input logic [31:0] va, input logic wr,
                           input logic [1:0] pm, input logic el,
                           input logic hit, input logic vld, input logic drt,
                           input logic [19:0] pfn, input logic [7:0] id,
                           input logic ld, input logic [31:0] ldd);
        logic e_ok, e_exc, e_ref, e_req, e_rd, e_wr, mapped, illegal;
        logic [31:0] e_pa;
        int e_code;
        string tag, ftag;
        e_ok = 0; e_exc = 0; e_ref = 0; e_req = 0; e_rd = 0; e_wr = 0;
        mapped = 0; illegal = 0; e_pa = 0; e_code = 0;
        tag = "R10"; ftag = "R10";
        if (rv) begin
            if (va < 32'h8000_0000) begin
                if (el) begin
                    tag = "R1"; e_ok = 1; e_pa = va; e_rd = 1; e_wr = 1;
                end else begin
                    tag = "R2"; mapped = 1;
                end
            end else if (va < 32'hA000_0000) begin
                tag = "R3";
                if (pm == 2'b00) begin e_ok = 1; e_pa = va - 32'h8000_0000; e_rd = 1; e_wr = 1; end
                else illegal = 1;
            end else if (va < 32'hC000_0000) begin
                tag = "R4";
                if (pm == 2'b00) begin e_ok = 1; e_pa = va - 32'hA000_0000; e_rd = 1; e_wr = 1; end
                else illegal = 1;
            end else if (va < 32'hE000_0000) begin
                tag = "R5";
                if (pm == 2'b00 || pm == 2'b01) mapped = 1; else illegal = 1;
            end else begin
                tag = "R5";
                if (pm == 2'b00) mapped = 1; else illegal = 1;
            end
            if (illegal) begin
                ftag = "R6"; e_exc = 1; e_code = wr ? 5 : 4;
            end
            if (mapped) begin
                e_req = 1;
                if (!hit) begin ftag = "R7"; e_exc = 1; e_code = wr ? 3 : 2; e_ref = 1; end
                else if (!vld) begin ftag = "R8"; e_exc = 1; e_code = wr ? 3 : 2; end
                else if (wr && !drt) begin ftag = "R9"; e_exc = 1; e_code = 1; end
                else begin
                    e_ok = 1; e_pa = {pfn, va[11:0]}; e_rd = 1; e_wr = drt;
                    if (!wr && !drt) ftag = "R9";
                end
            end
        end
        @(negedge clk);
        req_valid = rv; req_vaddr = va; req_write = wr; priv_mode = pm; err_level = el;
        tlb_hit = hit; tlb_valid = vld; tlb_dirty = drt; tlb_pfn = pfn; cur_id = id;
        ctx_load = ld; ctx_load_data = ldd;
        #1;
        check(tag, "tlb_req", {31'b0, tlb_req}, {31'b0, e_req});
        if (e_req) begin
            check("R2", "tlb_vpn2", {13'b0, tlb_vpn2}, {13'b0, va[31:13]});
            check("R2", "tlb_odd", {31'b0, tlb_odd}, {31'b0, va[12]});
        end
        check(tag, "phys_ok", {31'b0, phys_ok}, {31'b0, e_ok});
        if (e_ok) begin
            check(tag, "phys_addr", phys_addr, e_pa);
            check(tag, "perm", {30'b0, perm_rd, perm_wr}, {30'b0, e_rd, e_wr});
        end
        check(ftag, "exc_valid", {31'b0, exc_valid}, {31'b0, e_exc});
        if (e_exc) begin
            check(ftag, "exc_code", {27'b0, exc_code}, e_code);
            check(ftag, "exc_refill", {31'b0, exc_refill}, {31'b0, e_ref});
        end
        if (ld) m_ctx = ldd;
        if (e_exc) begin
            m_bad = va;
            m_ctx[22:4] = va[31:13];
            m_ehi = {va[31:13], 5'b0, id};
        end
        @(posedge clk);
        #1;
        check("R10", "bad_vaddr", bad_vaddr, m_bad);
        check("R11", "ctx_reg", ctx_reg, m_ctx);
        check("R12", "entry_hi", entry_hi, m_ehi);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog R10: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; req_valid = 0; req_vaddr = 0; req_write = 0; priv_mode = 0;
        err_level = 0; cur_id = 0; tlb_hit = 0; tlb_valid = 0; tlb_dirty = 0;
        tlb_pfn = 0; ctx_load = 0; ctx_load_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check("R10", "reset bad_vaddr", bad_vaddr, 0);
        check("R10", "reset ctx_reg", ctx_reg, 0);
        check("R10", "reset entry_hi", entry_hi, 0);
        // R1 identity in each mode
        run_vec(1, 32'h1234_5678, 0, 2'b10, 1, 0, 0, 0, 20'h0, 8'h11, 0, 0);
        run_vec(1, 32'h7FFF_FFFF, 1, 2'b00, 1, 0, 0, 0, 20'h0, 8'h11, 0, 0);
        // R2 mapped low segment: hit dirty, hit clean read
        run_vec(1, 32'h0040_3ABC, 1, 2'b10, 0, 1, 1, 1, 20'hABCDE, 8'h22, 0, 0);
        run_vec(1, 32'h0040_2ABC, 0, 2'b10, 0, 1, 1, 0, 20'h12345, 8'h22, 0, 0);
        // R3/R4 kernel windows and boundaries
        run_vec(1, 32'h8000_0000, 0, 2'b00, 0, 0, 0, 0, 20'h0, 8'h01, 0, 0);
        run_vec(1, 32'h9FFF_FFFF, 1, 2'b00, 0, 0, 0, 0, 20'h0, 8'h01, 0, 0);
        run_vec(1, 32'hA000_0010, 0, 2'b00, 0, 0, 0, 0, 20'h0, 8'h01, 0, 0);
        run_vec(1, 32'hBFFF_FFF0, 1, 2'b00, 1, 0, 0, 0, 20'h0, 8'h01, 0, 0);
        // R6 illegal windows from user / supervisor / reserved mode
        run_vec(1, 32'h8000_2000, 0, 2'b10, 0, 1, 1, 1, 20'h0, 8'h33, 0, 0);
        run_vec(1, 32'hA123_4000, 1, 2'b01, 0, 1, 1, 1, 20'h0, 8'h34, 0, 0);
        run_vec(1, 32'hC000_0000, 1, 2'b11, 0, 1, 1, 1, 20'h0, 8'h35, 0, 0);
        run_vec(1, 32'hE000_0000, 0, 2'b01, 0, 1, 1, 1, 20'h0, 8'h36, 0, 0);
        // R5 mapped high windows
        run_vec(1, 32'hC000_1FFF, 0, 2'b01, 0, 1, 1, 1, 20'hFEDCB, 8'h40, 0, 0);
        run_vec(1, 32'hFFFF_F000, 1, 2'b00, 0, 1, 1, 1, 20'h00001, 8'h41, 0, 0);
        // R7 miss, R8 invalid, R9 clean write
        run_vec(1, 32'h0001_E004, 0, 2'b10, 0, 0, 0, 0, 20'h0, 8'h55, 0, 0);
        run_vec(1, 32'hDEAD_B000, 1, 2'b00, 0, 0, 1, 1, 20'h0, 8'h56, 0, 0);
        run_vec(1, 32'h0002_0000, 1, 2'b10, 0, 1, 0, 1, 20'h0, 8'h57, 0, 0);
        run_vec(1, 32'hC800_0000, 0, 2'b01, 0, 1, 0, 0, 20'h0, 8'h58, 0, 0);
        run_vec(1, 32'h0003_3000, 1, 2'b00, 0, 1, 1, 0, 20'h0, 8'h59, 0, 0);
        // R11 context load alone, fault alone, then both together
        run_vec(0, 32'h0, 0, 2'b00, 0, 0, 0, 0, 20'h0, 8'h00, 1, 32'hF0F0_F0F5);
        run_vec(1, 32'hFFFF_E000, 0, 2'b10, 0, 0, 0, 0, 20'h0, 8'h77, 0, 0);
        run_vec(1, 32'hAAAA_A000, 1, 2'b10, 0, 0, 0, 0, 20'h0, 8'h78, 1, 32'h5A5A_5A5A);
        run_vec(1, 32'h0000_8000, 0, 2'b01, 0, 0, 0, 0, 20'h0, 8'h79, 1, 32'hFFFF_FFFF);
        // R10 idle and successful access leave registers
        run_vec(0, 32'hE000_0000, 1, 2'b10, 0, 0, 0, 0, 20'h0, 8'h99, 0, 0);
        run_vec(1, 32'h8765_4321, 0, 2'b00, 0, 0, 0, 0, 20'h0, 8'h9A, 0, 0);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rnd;
            rnd = $urandom;
            run_vec(rnd[0] | rnd[1], $urandom, rnd[2], rnd[4:3], rnd[5], rnd[6] | rnd[9],
                    rnd[7] | rnd[10], rnd[8], 20'($urandom), 8'($urandom),
                    rnd[11] & rnd[12], $urandom);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule